// File: doc/BRIEF.md
# Last-Frame Motion-Compensation Cache with Write Buffer

This block keeps the previously reconstructed frame on chip so that motion-compensation reads of that frame need not go to external memory. The frame is stored as a grid of blocks of `BLK_W` columns by `BLK_H` rows, one data word per block. Each decoded block of the current frame is passed at once to an external frame-buffer write port. It also goes into a small FIFO write buffer. A block overwrites its location in the on-chip store only when the buffer is full and pushes it out. Data from the last frame near the current decode position therefore stays readable for a while after the current frame has reached it.

A committed-position pointer, counted in raster order, records how far overwriting has progressed through the frame. A read whose reference index is zero names the last frame. It hits when its raster position is at or beyond the pointer, and the stored word is returned one cycle later. A read that falls behind the pointer, or that names an older reference frame, misses. The miss is sent as a request to the external frame buffer in the same cycle as the response. At a frame boundary the block drains the write buffer into the store one entry per cycle, holding `busy` high while it does so, and then returns the pointer to the frame origin. Blocks are assumed to be written in raster order.

Top module: `last_frame_cache`

## Requirements
- R1: After reset, `rsp_valid`, `fb_rd_valid`, `fb_wr_valid` and `busy` are all 0.
- R2: A write accepted while `busy` is 0 appears on the `fb_wr_*` outputs one cycle later with the same x, y and data.
- R3: A read with `rd_ref` = 0 whose raster position (y*BLK_W + x) is at or beyond the committed pointer gives `rsp_valid`=1 and `rsp_hit`=1 one cycle later, with `rsp_data` holding the last frame's word for that block, and no frame-buffer read.
- R4: A read with `rd_ref` = 0 whose raster position is behind the committed pointer gives `rsp_hit`=0, and in the same cycle `fb_rd_valid`=1 with the request's reference, x and y.
- R5: A read with a nonzero `rd_ref` always misses and is forwarded to the frame buffer, whatever its position.
- R6: The write buffer holds the WB_DEPTH most recent writes. A write commits the oldest entry only when the buffer is full, so a block just written still reads back its last-frame data.
- R7: A `frame_end` pulse raises `busy` on the next cycle. The buffer is then drained, `busy` falls, and the pointer is reset, so every block of the frame just finished reads as a hit that returns its new data.
- R8: Reads and writes presented while `busy` is 1 are ignored. They produce no response, no frame-buffer traffic and no change to the stored data.
- R9: With WB_DEPTH equal to BLK_W, a read of the block directly above the next block to be decoded hits, and the block one position earlier in raster order misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Decoded block write strobe |
| wr_x | input | X_W | Block column of the write |
| wr_y | input | Y_W | Block row of the write |
| wr_data | input | DATA_W | Decoded block data |
| rd_valid | input | 1 | Motion-compensation read strobe |
| rd_ref | input | REF_W | Reference index, 0 = last frame |
| rd_x | input | X_W | Block column of the read |
| rd_y | input | Y_W | Block row of the read |
| frame_end | input | 1 | Frame boundary pulse |
| rsp_valid | output | 1 | Read response strobe |
| rsp_hit | output | 1 | Response served on chip |
| rsp_data | output | DATA_W | Block data on a hit |
| fb_rd_valid | output | 1 | External frame-buffer read request |
| fb_rd_ref | output | REF_W | Reference index of the request |
| fb_rd_x | output | X_W | Block column of the request |
| fb_rd_y | output | Y_W | Block row of the request |
| fb_wr_valid | output | 1 | External frame-buffer write strobe |
| fb_wr_x | output | X_W | Block column of the write |
| fb_wr_y | output | Y_W | Block row of the write |
| fb_wr_data | output | DATA_W | Block data of the write |
| busy | output | 1 | Draining at a frame boundary |

## Verification
The hit decision is tried with three read patterns. A full sweep of the store right after a drain separates the stored data of one frame from that of the next. Reads of the block just written, of the block above the next decode position, and of the block one behind the pointer test the comparison at its exact boundary and show whether writes are buffered or written straight through. Reads with a nonzero reference index at every position show whether the bypass depends on position. Reads and writes issued during a drain, followed by a sweep, show whether the busy window really ignores traffic and leaves the store untouched.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [0:0] {ST_RUN = 1'b0, ST_DRAIN = 1'b1} lfc_state_e;
endpackage

// File: rtl/lfc_wbuf.sv
// FIFO of pending block writes, kept in decode order.
module lfc_wbuf #(
  parameter int ENTRY_W = 36,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               full,
  output logic               empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (pop && !push) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/lfc_store.sv
// Frame store, one word per block; synchronous read so block RAM fits.
module lfc_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int WORDS  = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lfc_lookup.sv
// Raster position of a request and the hit decision against the pointer.
module lfc_lookup #(
  parameter int BLK_W  = 4,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int REF_W  = 2,
  parameter int ADDR_W = 4,
  parameter int POS_W  = 5
) (
  input  logic [X_W-1:0]    x,
  input  logic [Y_W-1:0]    y,
  input  logic [REF_W-1:0]  ref_idx,
  input  logic [POS_W-1:0]  cptr,
  output logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign addr = ADDR_W'(y) * ADDR_W'(BLK_W) + ADDR_W'(x);
  assign hit  = (ref_idx == '0) && (POS_W'(addr) >= cptr);
endmodule

// File: rtl/last_frame_cache.sv
module last_frame_cache #(
  parameter int BLK_W    = 4,
  parameter int BLK_H    = 4,
  parameter int DATA_W   = 32,
  parameter int REF_W    = 2,
  parameter int WB_DEPTH = 4,
  localparam int X_W     = (BLK_W > 1) ? $clog2(BLK_W) : 1,
  localparam int Y_W     = (BLK_H > 1) ? $clog2(BLK_H) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [X_W-1:0]    wr_x,
  input  logic [Y_W-1:0]    wr_y,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [REF_W-1:0]  rd_ref,
  input  logic [X_W-1:0]    rd_x,
  input  logic [Y_W-1:0]    rd_y,
  input  logic              frame_end,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fb_rd_valid,
  output logic [REF_W-1:0]  fb_rd_ref,
  output logic [X_W-1:0]    fb_rd_x,
  output logic [Y_W-1:0]    fb_rd_y,
  output logic              fb_wr_valid,
  output logic [X_W-1:0]    fb_wr_x,
  output logic [Y_W-1:0]    fb_wr_y,
  output logic [DATA_W-1:0] fb_wr_data,
  output logic              busy
);
  import lfc_pkg::*;

  localparam int BLOCKS  = BLK_W * BLK_H;
  localparam int ADDR_W  = $clog2(BLOCKS);
  localparam int POS_W   = $clog2(BLOCKS + 1);
  localparam int ENTRY_W = ADDR_W + DATA_W;

  lfc_state_e        state;
  logic [POS_W-1:0]  cptr;
  logic              accept_wr, accept_rd;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              rd_hit;
  logic              wb_pop, wb_full, wb_empty;
  logic [ENTRY_W-1:0] wb_head;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;

  assign accept_wr = wr_valid && (state == ST_RUN);
  assign accept_rd = rd_valid && (state == ST_RUN);
  assign wr_addr   = ADDR_W'(wr_y) * ADDR_W'(BLK_W) + ADDR_W'(wr_x);
  assign head_addr = wb_head[ENTRY_W-1:DATA_W];
  assign head_data = wb_head[DATA_W-1:0];
  assign wb_pop    = (accept_wr && wb_full) || ((state == ST_DRAIN) && !wb_empty);
  assign busy      = (state == ST_DRAIN);

  lfc_lookup #(
    .BLK_W(BLK_W), .X_W(X_W), .Y_W(Y_W), .REF_W(REF_W),
    .ADDR_W(ADDR_W), .POS_W(POS_W)
  ) u_lookup (
    .x(rd_x), .y(rd_y), .ref_idx(rd_ref), .cptr(cptr),
    .addr(rd_addr), .hit(rd_hit)
  );

  lfc_wbuf #(.ENTRY_W(ENTRY_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst),
    .push(accept_wr), .push_data({wr_addr, wr_data}),
    .pop(wb_pop), .head(wb_head), .full(wb_full), .empty(wb_empty)
  );

  lfc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(BLOCKS)) u_store (
    .clk(clk),
    .we(wb_pop), .waddr(head_addr), .wdata(head_data),
    .re(accept_rd), .raddr(rd_addr), .rdata(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      cptr        <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      fb_rd_valid <= 1'b0;
      fb_wr_valid <= 1'b0;
    end else begin
      rsp_valid   <= accept_rd;
      rsp_hit     <= accept_rd && rd_hit;
      fb_rd_valid <= accept_rd && !rd_hit;
      fb_wr_valid <= accept_wr;
      if (wb_pop) cptr <= POS_W'(head_addr) + POS_W'(1);
      case (state)
        ST_RUN:   if (frame_end) state <= ST_DRAIN;
        ST_DRAIN: if (wb_empty) begin
          state <= ST_RUN;
          cptr  <= '0;
        end
        default:  state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept_rd) begin
      fb_rd_ref <= rd_ref;
      fb_rd_x   <= rd_x;
      fb_rd_y   <= rd_y;
    end
    if (accept_wr) begin
      fb_wr_x    <= wr_x;
      fb_wr_y    <= wr_y;
      fb_wr_data <= wr_data;
    end
  end
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int DATA_W = 32,
  parameter int REF_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic [REF_W-1:0]  rd_ref,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              fb_rd_valid,
  input logic              fb_wr_valid,
  input logic [DATA_W-1:0] fb_wr_data
);
  AST_WR_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !busy) |=> (fb_wr_valid && fb_wr_data == $past(wr_data))); // R2
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !fb_rd_valid); // R3
  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> fb_rd_valid); // R4
  AST_FETCH_HAS_RSP: assert property (@(posedge clk) disable iff (rst)
    fb_rd_valid |-> (rsp_valid && !rsp_hit)); // R4
  AST_OLD_REF_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !busy && rd_ref != '0) |=> (rsp_valid && !rsp_hit)); // R5
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (busy && (rd_valid || wr_valid)) |=> (!rsp_valid && !fb_wr_valid)); // R8
endmodule

bind last_frame_cache lfc_checker #(.DATA_W(DATA_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ref(rd_ref), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fb_rd_valid(fb_rd_valid),
  .fb_wr_valid(fb_wr_valid), .fb_wr_data(fb_wr_data)
);

// File: tb/last_frame_cache_tb.sv
module last_frame_cache_tb;
  localparam int BW = 4, BH = 4, DW = 32, RW = 2, WD = 4, NB = BW * BH;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 0, rd_valid = 0, frame_end = 0;
  logic [1:0] wr_x = 0, wr_y = 0, rd_x = 0, rd_y = 0;
  logic [DW-1:0] wr_data = 0;
  logic [RW-1:0] rd_ref = 0;
  logic rsp_valid, rsp_hit, fb_rd_valid, fb_wr_valid, busy;
  logic [DW-1:0] rsp_data, fb_wr_data;
  logic [RW-1:0] fb_rd_ref;
  logic [1:0] fb_rd_x, fb_rd_y, fb_wr_x, fb_wr_y;

  always #10 clk = ~clk;

  last_frame_cache #(.BLK_W(BW), .BLK_H(BH), .DATA_W(DW), .REF_W(RW), .WB_DEPTH(WD)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ref(rd_ref), .rd_x(rd_x), .rd_y(rd_y), .frame_end(frame_end),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fb_rd_valid(fb_rd_valid), .fb_rd_ref(fb_rd_ref), .fb_rd_x(fb_rd_x), .fb_rd_y(fb_rd_y),
    .fb_wr_valid(fb_wr_valid), .fb_wr_x(fb_wr_x), .fb_wr_y(fb_wr_y), .fb_wr_data(fb_wr_data),
    .busy(busy)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_mem [NB];
  bit            m_known [NB];
  int            wb_pos [$];
  logic [DW-1:0] wb_dat [$];
  int            m_cptr = 0;

  typedef struct packed { logic hit; logic chk; logic [DW-1:0] data; logic [RW-1:0] ridx; logic [1:0] x; logic [1:0] y; } rexp_t;
  typedef struct packed { logic [1:0] x; logic [1:0] y; logic [DW-1:0] data; } wexp_t;
  rexp_t rq [$];
  string rtag [$];
  wexp_t wq [$];

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (rq.size() == 0) chk(0, "R8", "unexpected response", 1, 0);
        else begin
          rexp_t e; string t;
          e = rq.pop_front(); t = rtag.pop_front();
          chk(rsp_hit == e.hit, t, "rsp_hit", rsp_hit, e.hit);
          if (e.hit && e.chk) chk(rsp_data == e.data, t, "rsp_data", rsp_data, e.data);
          chk(fb_rd_valid == !e.hit, t, "fb_rd_valid", fb_rd_valid, !e.hit);
          if (!e.hit)
            chk({fb_rd_ref, fb_rd_x, fb_rd_y} == {e.ridx, e.x, e.y}, t, "fb_rd fields",
                {fb_rd_ref, fb_rd_x, fb_rd_y}, {e.ridx, e.x, e.y});
        end
      end else if (fb_rd_valid) chk(0, "R4", "fetch without response", 1, 0);
      if (fb_wr_valid) begin
        if (wq.size() == 0) chk(0, "R8", "unexpected fb write", 1, 0);
        else begin
          wexp_t w;
          w = wq.pop_front();
          chk({fb_wr_x, fb_wr_y, fb_wr_data} == w, "R2", "fb write",
              {fb_wr_x, fb_wr_y, fb_wr_data}, w);
        end
      end
    end
  end

  task automatic do_write(input int pos, input logic [DW-1:0] d);
    wq.push_back({2'(pos % BW), 2'(pos / BW), d});
    if (wb_pos.size() == WD) begin
      int p;
      p = wb_pos.pop_front();
      m_mem[p] = wb_dat.pop_front();
      m_known[p] = 1;
      m_cptr = p + 1;
    end
    wb_pos.push_back(pos); wb_dat.push_back(d);
    wr_valid = 1; wr_x = 2'(pos % BW); wr_y = 2'(pos / BW); wr_data = d;
    @(posedge clk); #2 wr_valid = 0;
  endtask

  task automatic do_read(input int pos, input logic [RW-1:0] r, input string tag);
    rexp_t e;
    e.hit = (r == 0) && (pos >= m_cptr);
    e.chk = m_known[pos];
    e.data = m_mem[pos];
    e.ridx = r; e.x = 2'(pos % BW); e.y = 2'(pos / BW);
    rq.push_back(e); rtag.push_back(tag);
    rd_valid = 1; rd_ref = r; rd_x = e.x; rd_y = e.y;
    @(posedge clk); #2 rd_valid = 0;
  endtask

  task automatic do_frame_end();
    int guard;
    frame_end = 1;
    @(posedge clk); #2 frame_end = 0;
    chk(busy == 1, "R7", "busy after frame_end", busy, 1);
    // traffic during the drain must be ignored (R8)
    rd_valid = 1; rd_ref = 0; rd_x = 0; rd_y = 0;
    wr_valid = 1; wr_x = 0; wr_y = 0; wr_data = 32'hDEAD_BEEF;
    @(posedge clk); #2 rd_valid = 0; wr_valid = 0;
    @(negedge clk);
    chk(!rsp_valid && !fb_wr_valid, "R8", "outputs during drain", {rsp_valid, fb_wr_valid}, 0);
    guard = 0;
    while (busy && guard < 50) begin @(posedge clk); #2 guard++; end
    chk(!busy, "R7", "drain finished", busy, 0);
    while (wb_pos.size() > 0) begin
      int p;
      p = wb_pos.pop_front();
      m_mem[p] = wb_dat.pop_front();
      m_known[p] = 1;
    end
    m_cptr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run timed out", 1, 0);
    report();
  end

  initial begin
    for (int i = 0; i < NB; i++) m_known[i] = 0;
    repeat (4) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk({rsp_valid, fb_rd_valid, fb_wr_valid, busy} == 0, "R1", "reset outputs",
        {rsp_valid, fb_rd_valid, fb_wr_valid, busy}, 0);

    // frame A
    for (int n = 0; n < NB; n++) begin
      do_write(n, 32'hA000 + n);
      do_read(n, 1, "R5");
      do_read(n, 0, "R6");
      if (n >= WD) do_read(n - WD, 0, "R4");
    end
    do_frame_end();

    // whole store after drain, also proves the ignored write changed nothing
    for (int p = 0; p < NB; p++) do_read(p, 0, "R3");
    do_read(5, 2, "R5");

    // frame B
    for (int n = 0; n < NB; n++) begin
      do_write(n, 32'hB000 + n);
      do_read(n, 0, "R6");
      if (n + 1 < NB && n + 1 >= BW) do_read(n + 1 - BW, 0, "R9");
      if (n >= WD) do_read(n - WD, 0, "R9");
      do_read(NB - 1 - n, 3, "R5");
    end
    do_frame_end();
    for (int p = 0; p < NB; p++) do_read(p, 0, "R7");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rq.size() == 0 && wq.size() == 0, "R2", "all expected outputs seen", rq.size() + wq.size(), 0);
    done = 1;
    report();
  end
endmodule